// File: doc/BRIEF.md
# Twin Output Port Picker

This block joins two network-output units so that they act as a single logical output. Every issued operation reaches both units. Each unit XORs the two shared random inputs and compares the result with its own unit number. The unit that matches transmits the attempt. The other unit waits in standby.

When an attempt fails, the transmitting unit raises a shared retry line for one cycle. Both units count that retry, advance their status-log pointer and then pick again from the random inputs. The failed attempt is written to a status log at the current pointer. A successful open is logged only when that option is enabled. Once the captured retry limit is used up, the active unit stops and reports failure.

Each unit runs its own state machine. The states are IDLE, ACTIVE (transmitting), STANDBY (the other unit holds the attempt), RETRY (raising the shared line), RESEL (re-picking) and the terminal states OK and FAIL. The transitions are:
- issue goes to ACTIVE or STANDBY, from any state;
- ACTIVE goes to OK on success, to RETRY on a failure below the limit, and to FAIL on a failure at the limit;
- RETRY goes to RESEL;
- STANDBY goes to RESEL when it sees the retry line;
- RESEL goes to ACTIVE or STANDBY.

Top module: `twin_port_picker`

## Requirements
- R1: After reset, no unit transmits, is busy, or shows failed or succeeded. The retry line and the log strobe are 0.
- R2: The cycle after `op_issue`, unit k (k = 0 or 1) transmits exactly when `rnd_a ^ rnd_b == k`, as sampled with the issue; `xmit[k]` is set for that unit only. A completion report on the standby unit's `link_done` bit is ignored: no log strobe, no retry and no change of state.
- R3: When the active unit sees a failed report (`link_done=1`, `link_ok=0`) with its retry count below the limit, `retry_line` is 1 during the next cycle only.
- R4: In the cycle after `retry_line` is 1, both units are busy and neither transmits. The random bits sampled in that cycle pick the next transmitter by the rule in R2.
- R5: The retry counts of both units are cleared on issue. Both counts rise by one on each retry-line cycle, so the two counts are always equal.
- R6: A failed report when the retry count equals the limit (`cfg_limit`, captured at issue) raises no retry line. That unit goes to failed (`failed[k]=1`, not busy), and nothing more is attempted.
- R7: The status pointer loads `ptr_base` on issue and rises by 8 (one double word) per retry. Every failed report gives `log_we=1` with `log_addr` equal to the current pointer and `log_ok=0`.
- R8: A successful report sets `succeeded[k]`. It gives `log_we=1` with `log_ok=1` only if `cfg_log_ok` was 1 at issue; otherwise there is no strobe.
- R9: `op_issue` in any state restarts both units: the counts clear, the pointer reloads and a new pick is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_issue | input | 1 | Pulse: a new operation is issued to both units |
| rnd_a | input | 1 | Shared random bit A |
| rnd_b | input | 1 | Shared random bit B |
| cfg_limit | input | CNT_W | Retry limit, captured on issue |
| cfg_log_ok | input | 1 | Log successful opens, captured on issue |
| ptr_base | input | PTR_W | Status log start address, captured on issue |
| link_done | input | 2 | Per-unit attempt-finished report |
| link_ok | input | 2 | Per-unit attempt result (1 = opened) |
| xmit | output | 2 | Unit is transmitting the current attempt |
| busy | output | 2 | Unit is transmitting, retrying or re-picking |
| failed | output | 2 | Unit gave up after the limit |
| succeeded | output | 2 | Unit opened the connection |
| retry_line | output | 1 | Shared retransmit request |
| log_we | output | 1 | Status log write strobe |
| log_ok | output | 1 | Logged attempt result |
| log_addr | output | PTR_W | Status log address |
| retry_cnt | output | 2*CNT_W | Retry counts, unit 0 in the low bits |

## Verification
The bench walks attempt sequences in which the XOR pick lands on either unit and changes from one retry to the next. A design that compared against the wrong unit number, or re-picked on stale random bits, would light the wrong `xmit` bit. The sequences cover a limit of zero and success on the very last allowed attempt. An off-by-one give-up test would either raise one retry too many or fail one attempt too early. Pointer and count checks after each retry catch a standby unit that does not follow the shared line. Directed cases cover a report on the standby unit's link and an issue during ACTIVE or RESEL. A design that did not restart cleanly would leave stale counts or log to an old address.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    typedef enum logic [2:0] {
        U_IDLE    = 3'd0,
        U_ACTIVE  = 3'd1,
        U_STANDBY = 3'd2,
        U_RETRY   = 3'd3,
        U_RESEL   = 3'd4,
        U_OK      = 3'd5,
        U_FAIL    = 3'd6
    } unit_state_e;
endpackage

// File: rtl/attempt_tally.sv
module attempt_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] lim_d,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            lim_q <= lim_d;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt      = cnt_q;
    assign at_limit = (cnt_q == lim_q);

    // R5: a count step moves by exactly one
    p_tally_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/log_cursor.sv
module log_cursor #(
    parameter int PTR_W = 16,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] base,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (load) ptr_q <= base;
        else if (adv)  ptr_q <= ptr_q + PTR_W'(STEP);
    end

    assign ptr = ptr_q;

    // R7: one double word per attempt
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (ptr_q == $past(ptr_q) + PTR_W'(STEP)));
endmodule

// File: rtl/picker_unit.sv
module picker_unit
    import tpp_pkg::*;
#(
    parameter int UNIT_ID = 0,
    parameter int CNT_W   = 4,
    parameter int PTR_W   = 16,
    parameter int STEP    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_issue,
    input  logic             rnd_a,
    input  logic             rnd_b,
    input  logic             retry_in,
    input  logic             link_done,
    input  logic             link_ok,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_log_ok,
    input  logic [PTR_W-1:0] ptr_base,
    output logic             xmit,
    output logic             busy,
    output logic             failed,
    output logic             succeeded,
    output logic             retry_out,
    output logic             log_we,
    output logic             log_ok,
    output logic [PTR_W-1:0] log_addr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic MY_ID = UNIT_ID[0];

    unit_state_e      state_q, state_d;
    logic             log_ok_en_q;
    logic             sel_me;
    logic             at_limit;
    logic             step;
    logic [PTR_W-1:0] ptr;

    assign sel_me = ((rnd_a ^ rnd_b) == MY_ID);
    assign step   = retry_in && !op_issue &&
                    ((state_q == U_STANDBY) || (state_q == U_RETRY));

    attempt_tally #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (op_issue),
        .inc      (step),
        .lim_d    (cfg_limit),
        .cnt      (cnt),
        .at_limit (at_limit)
    );

    log_cursor #(.PTR_W(PTR_W), .STEP(STEP)) u_cursor (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_issue),
        .base  (ptr_base),
        .adv   (step),
        .ptr   (ptr)
    );

    always_comb begin
        state_d = state_q;
        if (op_issue) begin
            state_d = sel_me ? U_ACTIVE : U_STANDBY;
        end else begin
            unique case (state_q)
                U_IDLE, U_OK, U_FAIL: state_d = state_q;
                U_ACTIVE: begin
                    if (link_done) begin
                        if (link_ok)       state_d = U_OK;
                        else if (at_limit) state_d = U_FAIL;
                        else               state_d = U_RETRY;
                    end
                end
                U_STANDBY: if (retry_in) state_d = U_RESEL;
                U_RETRY:   state_d = U_RESEL;
                U_RESEL:   state_d = sel_me ? U_ACTIVE : U_STANDBY;
                default:   state_d = U_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= U_IDLE;
            log_ok_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (op_issue) log_ok_en_q <= cfg_log_ok;
        end
    end

    always_comb begin
        xmit      = (state_q == U_ACTIVE);
        busy      = (state_q == U_ACTIVE) || (state_q == U_RETRY) ||
                    (state_q == U_RESEL);
        retry_out = (state_q == U_RETRY);
        failed    = (state_q == U_FAIL);
        succeeded = (state_q == U_OK);
        log_we    = (state_q == U_ACTIVE) && link_done &&
                    (!link_ok || log_ok_en_q);
        log_ok    = link_ok;
        log_addr  = ptr;
    end

    // R4: both the raiser and the standby unit re-pick after the line
    p_resel_after_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state_q == U_RESEL));
    // R6: give up only at the limit
    p_fail_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit && link_done && !link_ok && at_limit && !op_issue) |=> failed);
    // R7: every failed report is logged
    p_log_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit && link_done && !link_ok) |-> (log_we && !log_ok));
    // R2: the standby unit never logs
    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == U_STANDBY) |-> !log_we);
endmodule

// File: rtl/twin_port_picker.sv
module twin_port_picker #(
    parameter int CNT_W = 4,
    parameter int PTR_W = 16,
    parameter int STEP  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_issue,
    input  logic               rnd_a,
    input  logic               rnd_b,
    input  logic [CNT_W-1:0]   cfg_limit,
    input  logic               cfg_log_ok,
    input  logic [PTR_W-1:0]   ptr_base,
    input  logic [1:0]         link_done,
    input  logic [1:0]         link_ok,
    output logic [1:0]         xmit,
    output logic [1:0]         busy,
    output logic [1:0]         failed,
    output logic [1:0]         succeeded,
    output logic               retry_line,
    output logic               log_we,
    output logic               log_ok,
    output logic [PTR_W-1:0]   log_addr,
    output logic [2*CNT_W-1:0] retry_cnt
);
    localparam int UNITS = 2;

    logic [UNITS-1:0] retry_v;
    logic [UNITS-1:0] we_v;
    logic [UNITS-1:0] ok_v;
    logic [PTR_W-1:0] addr_v [UNITS];
    logic [CNT_W-1:0] cnt_v  [UNITS];

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        picker_unit #(
            .UNIT_ID (g),
            .CNT_W   (CNT_W),
            .PTR_W   (PTR_W),
            .STEP    (STEP)
        ) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .op_issue   (op_issue),
            .rnd_a      (rnd_a),
            .rnd_b      (rnd_b),
            .retry_in   (retry_line),
            .link_done  (link_done[g]),
            .link_ok    (link_ok[g]),
            .cfg_limit  (cfg_limit),
            .cfg_log_ok (cfg_log_ok),
            .ptr_base   (ptr_base),
            .xmit       (xmit[g]),
            .busy       (busy[g]),
            .failed     (failed[g]),
            .succeeded  (succeeded[g]),
            .retry_out  (retry_v[g]),
            .log_we     (we_v[g]),
            .log_ok     (ok_v[g]),
            .log_addr   (addr_v[g]),
            .cnt        (cnt_v[g])
        );
        assign retry_cnt[g*CNT_W +: CNT_W] = cnt_v[g];
    end

    assign retry_line = |retry_v;

    always_comb begin
        log_we   = 1'b0;
        log_ok   = 1'b0;
        log_addr = '0;
        for (int i = 0; i < UNITS; i++) begin
            if (we_v[i]) begin
                log_we   = 1'b1;
                log_ok   = ok_v[i];
                log_addr = addr_v[i];
            end
        end
    end

    // R2: never two transmitters
    p_single_xmit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xmit));
    // R3: only one raiser, for one cycle
    p_single_raiser_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retry_v));
    p_retry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retry_line |=> !retry_line);
    // R5: counts stay in step
    p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_v[0] == cnt_v[1]);
    // R4: nobody transmits while re-picking
    p_no_xmit_after_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_line && !op_issue) |=> (xmit == 2'b00));
endmodule

// File: tb/twin_port_picker_tb.sv
module twin_port_picker_tb;
    localparam int CNT_W = 4;
    localparam int PTR_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               op_issue = 1'b0;
    logic               rnd_a = 1'b0;
    logic               rnd_b = 1'b0;
    logic [CNT_W-1:0]   cfg_limit = '0;
    logic               cfg_log_ok = 1'b0;
    logic [PTR_W-1:0]   ptr_base = '0;
    logic [1:0]         link_done = '0;
    logic [1:0]         link_ok = '0;
    logic [1:0]         xmit, busy, failed, succeeded;
    logic               retry_line, log_we, log_ok;
    logic [PTR_W-1:0]   log_addr;
    logic [2*CNT_W-1:0] retry_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    twin_port_picker #(.CNT_W(CNT_W), .PTR_W(PTR_W), .STEP(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_issue(op_issue), .rnd_a(rnd_a),
        .rnd_b(rnd_b), .cfg_limit(cfg_limit), .cfg_log_ok(cfg_log_ok),
        .ptr_base(ptr_base), .link_done(link_done), .link_ok(link_ok),
        .xmit(xmit), .busy(busy), .failed(failed), .succeeded(succeeded),
        .retry_line(retry_line), .log_we(log_we), .log_ok(log_ok),
        .log_addr(log_addr), .retry_cnt(retry_cnt)
    );

    // {rnd pairs for attempts 3..0 (a,b), failures before success (7 = none), limit, log ok}
    localparam logic [14:0] VEC [0:7] = '{
        {8'b00000000, 3'd0, 3'd3, 1'b0},
        {8'b00000001, 3'd0, 3'd3, 1'b1},
        {8'b00011110, 3'd2, 3'd3, 1'b1},
        {8'b00100111, 3'd7, 3'd2, 1'b0},
        {8'b00000010, 3'd7, 3'd0, 1'b1},
        {8'b11001001, 3'd3, 3'd3, 1'b0},
        {8'b01100011, 3'd7, 3'd3, 1'b1},
        {8'b00001100, 3'd1, 3'd1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] rp, input int lim, input bit logen, input logic [PTR_W-1:0] base);
        op_issue   = 1'b1;
        rnd_a      = rp[1];
        rnd_b      = rp[0];
        cfg_limit  = CNT_W'(lim);
        cfg_log_ok = logen;
        ptr_base   = base;
        tick();
        op_issue = 1'b0;
    endtask

    task automatic run_case(input logic [7:0] rseq, input int nfail, input int lim,
                            input bit logen, input logic [PTR_W-1:0] base);
        logic [PTR_W-1:0] eptr;
        eptr = base;
        issue(rseq[1:0], lim, logen, base);
        for (int a = 0; a <= lim; a++) begin
            logic [1:0] rp;
            int u;
            bit ok;
            rp = rseq[2*a +: 2];
            u  = int'(rp[1] ^ rp[0]);
            ok = (a == nfail);
            #1;
            check("R2 transmitter pick", 32'(xmit), 32'(2'b01 << u));
            check("R5 count unit0", 32'(retry_cnt[CNT_W-1:0]), 32'(a));
            check("R5 count unit1", 32'(retry_cnt[2*CNT_W-1:CNT_W]), 32'(a));
            link_done[u] = 1'b1;
            link_ok[u]   = ok;
            #1;
            if (ok) begin
                check("R8 success log strobe", 32'(log_we), 32'(logen));
                if (logen) check("R8 success log bit", 32'(log_ok), 32'd1);
            end else begin
                check("R7 fail log strobe", 32'(log_we), 32'd1);
                check("R7 fail log bit", 32'(log_ok), 32'd0);
            end
            if (log_we) check("R7 log address", 32'(log_addr), 32'(eptr));
            tick();
            link_done = '0;
            link_ok   = '0;
            if (ok) begin
                check("R8 succeeded flag", 32'(succeeded), 32'(2'b01 << u));
                check("R8 not busy", 32'(busy), 32'd0);
                return;
            end
            if (a == lim) begin
                check("R6 failed flag", 32'(failed), 32'(2'b01 << u));
                check("R6 no retry at limit", 32'(retry_line), 32'd0);
                check("R6 not busy", 32'(busy), 32'd0);
                tick();
                check("R6 stays stopped", 32'(xmit), 32'd0);
                return;
            end
            check("R3 retry line raised", 32'(retry_line), 32'd1);
            tick();
            check("R3 retry line one cycle", 32'(retry_line), 32'd0);
            check("R4 both re-picking", 32'(busy), 32'(2'b11));
            check("R4 no transmitter", 32'(xmit), 32'd0);
            eptr = eptr + PTR_W'(8);
            rnd_a = rseq[2*(a+1) + 1];
            rnd_b = rseq[2*(a+1)];
            tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset xmit", 32'(xmit), 32'd0);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset flags", 32'({failed, succeeded}), 32'd0);
        check("R1 reset retry", 32'(retry_line), 32'd0);
        check("R1 reset log", 32'(log_we), 32'd0);

        for (int i = 0; i < 8; i++) begin
            logic [14:0] v;
            v = VEC[i];
            run_case(v[14:7], int'(v[6:4]), int'(v[3:1]), v[0],
                     PTR_W'(16'h1000 + i * 16'h100));
            tick();
        end

        // R2: report on the standby unit's link is ignored
        issue(2'b01, 2, 1'b1, 16'h4000);
        link_done[0] = 1'b1;
        link_ok[0]   = 1'b0;
        #1;
        check("R2 standby report no log", 32'(log_we), 32'd0);
        tick();
        link_done = '0;
        check("R2 standby report no retry", 32'(retry_line), 32'd0);
        check("R2 active unchanged", 32'(xmit), 32'(2'b10));

        // R9: issue while ACTIVE restarts with a fresh pick
        issue(2'b11, 2, 1'b1, 16'h5000);
        check("R9 re-pick on issue", 32'(xmit), 32'(2'b01));

        // R9: issue during RESEL clears counts and reloads pointer
        link_done[0] = 1'b1;
        link_ok[0]   = 1'b0;
        tick();
        link_done = '0;
        tick();
        check("R9 re-picking before restart", 32'(busy), 32'(2'b11));
        check("R5 count after retry", 32'(retry_cnt), 32'(8'h11));
        issue(2'b10, 2, 1'b1, 16'h6000);
        check("R9 count cleared", 32'(retry_cnt), 32'd0);
        check("R9 new transmitter", 32'(xmit), 32'(2'b10));
        link_done[1] = 1'b1;
        link_ok[1]   = 1'b1;
        #1;
        check("R9 log at new base", 32'(log_addr), 32'h6000);
        tick();
        link_done = '0;
        link_ok   = '0;
        check("R9 success after restart", 32'(succeeded), 32'(2'b10));

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule